// File: doc/BRIEF.md
# Card Clock Divider with Data-Phase Timeout

This block derives a memory-card bus clock from the base clock using a power-of-two ratio from 1 to 512. The ratio is requested as a plain binary value and reported back as an encoded 8-bit status field. Software-style requests turn the card clock on or off, or change its ratio.

Requests come in over a valid/ready handshake. The block accepts a request only while `req_ready` is high, which is only when it is idle. It cannot stall the response: exactly one `resp_valid` pulse with a result code follows each accepted request. A ratio change runs a fixed sequence: stop the clock at a falling edge, load the new ratio, restart.

A data-phase watchdog counts card-clock rising edges while `data_wait` is held. It raises a one-cycle `tmo_pulse` when the count reaches a length that depends on the ratio. The block also reports a timeout select code that matches that length.

Top module: `cardclk_div`

## Requirements
- R1: Status field `div_code` reads 0xFF while the ratio is 1 and 0x00 while it is 2.
- R2: Ratios 4, 8, 16, 32, 64, 128, 256 and 512 report `div_code` 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40 and 0x80 respectively (bit k-2 set for ratio 2^k).
- R3: A request accepted while `cmd_busy` is high answers `resp_code` 1 (busy) one cycle later, and the ratio and run state stay unchanged.
- R4: A start request for the ratio already running answers `resp_code` 0 in the cycle after acceptance, and nothing changes.
- R5: A ratio change stops the clock only at the end of a high phase, loads the new ratio while stopped, then restarts. The ratio never changes while running, and a stopped clock is held low.
- R6: While running at ratio R≥2, `card_clk` has a period of R base cycles, high R/2 and low R/2. At ratio 1 it follows the base clock.
- R7: With `data_wait` held, `tmo_pulse` rises once, for one cycle, after 2^(E-TMO_SCALE) card-clock rising edges. E is 27 for ratios 1 and 2, drops by one for each further doubling down to 20 at ratio 256, and stays 20 at 512. Releasing `data_wait` earlier clears the count and gives no pulse.
- R8: `tmo_sel` reads 0xE0 for ratios 1 and 2, 0xD0, 0xC0, 0xB0, 0xA0, 0x90, 0x80 for ratios 4 to 128, and 0x70 for 256 and 512.
- R9: A start request whose ratio is not a power of two from 1 to 512 answers `resp_code` 2 (parameter) one cycle later and leaves the setting unchanged. Stop requests ignore the ratio field. Busy takes priority over parameter.
- R10: Reset leaves the clock stopped and low at ratio 512 with `req_ready` high. A stop request answers `resp_code` 0 and holds `card_clk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_ratio | input | 11 | Requested divide ratio, binary |
| req_on | input | 1 | 1 = run at req_ratio, 0 = stop clock |
| cmd_busy | input | 1 | Command path busy, requests rejected |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_code | output | 2 | 0 ok, 1 busy, 2 parameter error |
| data_wait | input | 1 | Arms the data-phase timeout |
| card_clk | output | 1 | Gated, divided card clock |
| div_code | output | 8 | Encoded current ratio |
| clk_running | output | 1 | Card clock enabled |
| tmo_sel | output | 8 | Timeout select code for current ratio |
| tmo_pulse | output | 1 | Timeout expiry pulse |

## Verification
Rejections and already-running requests answer in the first cycle after acceptance. The bench checks that latency exactly, together with the unchanged status fields. A ratio change answers only after the clock reaches its next falling edge, so the bench waits for `resp_valid` and then checks the new code, the select field and the clock shape. Clock shape is sampled a quarter period after each base edge. The timeout pulse lags arming by a phase-dependent number of card-clock periods, so its arrival is checked against 2^E·R cycles within one card-clock period plus two cycles, and it must be followed by a low sample.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  localparam int RATIO_W = 11;
  localparam int K_W     = 4;
  localparam int MAX_K   = 9;

  typedef enum logic [1:0] {RC_OK = 2'd0, RC_BUSY = 2'd1, RC_PARAM = 2'd2} resp_t;

  function automatic logic ratio_ok(input logic [RATIO_W-1:0] r);
    return ($countones(r) == 1) && (r[RATIO_W-1:MAX_K+1] == '0);
  endfunction

  function automatic logic [K_W-1:0] ratio_log2(input logic [RATIO_W-1:0] r);
    logic [K_W-1:0] k;
    k = '0;
    for (int i = 0; i <= MAX_K; i++)
      if (r[i]) k = K_W'(i);
    return k;
  endfunction

  function automatic logic [7:0] code_of(input logic [K_W-1:0] k);
    if (k == 0) return 8'hFF;
    if (k == 1) return 8'h00;
    return 8'(1) << (k - 2);
  endfunction

  // steps below the longest timeout, clamped to 0..7
  function automatic int unsigned tmo_drop(input logic [K_W-1:0] k);
    if (k <= 1) return 0;
    if (k >= 8) return 7;
    return int'(k) - 1;
  endfunction

  function automatic logic [7:0] sel_of(input logic [K_W-1:0] k);
    return 8'hE0 - 8'(tmo_drop(k) * 16);
  endfunction
endpackage

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [K_W-1:0] k,
  output logic           card_clk,
  output logic           tick,
  output logic           stop_ok
);
  localparam int CW = MAX_K;

  logic [CW-1:0] cnt;
  logic          div_q;
  logic          gate_n;
  logic [CW-1:0] half_m1;
  logic          edge_now;

  always_comb begin
    half_m1  = (k == 0) ? '0 : CW'((10'd1 << (k - 1)) - 10'd1);
    edge_now = (cnt == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (!run || k == 0) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else if (edge_now) begin
      cnt   <= '0;
      div_q <= ~div_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // pass-through gate updates in the low phase of the base clock
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n <= 1'b0;
    else        gate_n <= run && (k == 0);
  end

  always_comb begin
    card_clk = (k == 0) ? (clk & gate_n) : div_q;
    tick     = run && ((k == 0) || (edge_now && !div_q));
    // stop exactly where a high phase ends
    stop_ok  = (k == 0) || (div_q && edge_now);
  end

  p_high_ends_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && k != 0 && stop_ok) |=> !div_q);
  p_no_toggle_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !div_q);
endmodule

// File: rtl/cardclk_tmo.sv
module cardclk_tmo
  import cardclk_pkg::*;
#(
  parameter int TMO_SCALE = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           armed,
  input  logic [K_W-1:0] k,
  output logic [7:0]     tmo_sel,
  output logic           tmo_pulse
);
  localparam int E_MAX = 27;
  localparam int TW    = E_MAX + 1 - TMO_SCALE;

  logic [TW-1:0] tcnt;
  logic [TW-1:0] last_v;
  logic          fired;
  int unsigned   e;

  always_comb begin
    e       = E_MAX - tmo_drop(k) - TMO_SCALE;
    last_v  = TW'((64'd1 << e) - 64'd1);
    tmo_sel = sel_of(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt      <= '0;
      fired     <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (!armed) begin
        tcnt  <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (tcnt == last_v) begin
          fired     <= 1'b1;
          tmo_pulse <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  p_tmo_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);
  p_tmo_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> $past(armed));
  p_sel_grid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_sel[3:0] == 4'h0) && (tmo_sel >= 8'h70) && (tmo_sel <= 8'hE0));
endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [RATIO_W-1:0] req_ratio,
  input  logic               req_on,
  input  logic               cmd_busy,
  input  logic               stop_ok,
  output logic               resp_valid,
  output logic [1:0]         resp_code,
  output logic               run_q,
  output logic [K_W-1:0]     cur_k
);
  typedef enum logic [1:0] {S_IDLE, S_STOP, S_LOAD, S_START} st_t;

  st_t            st;
  logic [K_W-1:0] pend_k;
  logic           pend_on;
  logic           accept;
  logic           r_ok;
  logic [K_W-1:0] r_k;

  always_comb begin
    req_ready = (st == S_IDLE);
    accept    = req_valid && req_ready;
    r_ok      = ratio_ok(req_ratio);
    r_k       = ratio_log2(req_ratio);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      run_q      <= 1'b0;
      cur_k      <= K_W'(MAX_K);
      pend_k     <= '0;
      pend_on    <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= RC_OK;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (cmd_busy) begin
            resp_valid <= 1'b1;
            resp_code  <= RC_BUSY;
          end else if (!req_on) begin
            pend_on <= 1'b0;
            if (run_q) st <= S_STOP;
            else begin
              resp_valid <= 1'b1;
              resp_code  <= RC_OK;
            end
          end else if (!r_ok) begin
            resp_valid <= 1'b1;
            resp_code  <= RC_PARAM;
          end else if (run_q && r_k == cur_k) begin
            resp_valid <= 1'b1;
            resp_code  <= RC_OK;
          end else begin
            pend_on <= 1'b1;
            pend_k  <= r_k;
            st      <= run_q ? S_STOP : S_LOAD;
          end
        end
        S_STOP: if (stop_ok) begin
          run_q <= 1'b0;
          if (pend_on) st <= S_LOAD;
          else begin
            st         <= S_IDLE;
            resp_valid <= 1'b1;
            resp_code  <= RC_OK;
          end
        end
        S_LOAD: begin
          cur_k <= pend_k;
          st    <= S_START;
        end
        default: begin
          run_q      <= 1'b1;
          resp_valid <= 1'b1;
          resp_code  <= RC_OK;
          st         <= S_IDLE;
        end
      endcase
    end
  end

  p_busy_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_busy) |=> (resp_valid && resp_code == RC_BUSY && run_q == $past(run_q)
                              && cur_k == $past(cur_k)));
  p_same_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_busy && req_on && r_ok && run_q && r_k == cur_k)
      |=> (resp_valid && resp_code == RC_OK && run_q && cur_k == $past(cur_k)));
  p_frozen_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (cur_k == $past(cur_k)));
  p_param_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_busy && req_on && !r_ok) |=> (resp_valid && resp_code == RC_PARAM
                                                  && cur_k == $past(cur_k)));
endmodule

// File: rtl/cardclk_div.sv
module cardclk_div
  import cardclk_pkg::*;
#(
  parameter int TMO_SCALE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [10:0]  req_ratio,
  input  logic         req_on,
  input  logic         cmd_busy,
  output logic         resp_valid,
  output logic [1:0]   resp_code,
  input  logic         data_wait,
  output logic         card_clk,
  output logic [7:0]   div_code,
  output logic         clk_running,
  output logic [7:0]   tmo_sel,
  output logic         tmo_pulse
);
  logic           run_q;
  logic [K_W-1:0] cur_k;
  logic           tick;
  logic           stop_ok;

  cardclk_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_ratio, .req_on, .cmd_busy,
    .stop_ok, .resp_valid, .resp_code, .run_q, .cur_k
  );

  cardclk_gen u_gen (
    .clk, .rst_n, .run(run_q), .k(cur_k), .card_clk, .tick, .stop_ok
  );

  cardclk_tmo #(.TMO_SCALE(TMO_SCALE)) u_tmo (
    .clk, .rst_n, .tick, .armed(data_wait), .k(cur_k), .tmo_sel, .tmo_pulse
  );

  assign div_code    = code_of(cur_k);
  assign clk_running = run_q;
endmodule

// File: tb/cardclk_div_bench.sv
module cardclk_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_ratio = '0;
  logic        req_on = 1'b0;
  logic        cmd_busy = 1'b0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic        data_wait = 1'b0;
  logic        card_clk;
  logic [7:0]  div_code;
  logic        clk_running;
  logic [7:0]  tmo_sel;
  logic        tmo_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cardclk_div #(.TMO_SCALE(18)) u_cardclk_div (.*);

  always #10 clk = ~clk;

  // {ratio, div_code, tmo_sel, timeout length in card clocks at scale 18}
  localparam logic [37:0] VEC [10] = '{
    {11'd1,   8'hFF, 8'hE0, 11'd512},
    {11'd2,   8'h00, 8'hE0, 11'd512},
    {11'd4,   8'h01, 8'hD0, 11'd256},
    {11'd8,   8'h02, 8'hC0, 11'd128},
    {11'd16,  8'h04, 8'hB0, 11'd64},
    {11'd32,  8'h08, 8'hA0, 11'd32},
    {11'd64,  8'h10, 8'h90, 11'd16},
    {11'd128, 8'h20, 8'h80, 11'd8},
    {11'd256, 8'h40, 8'h70, 11'd4},
    {11'd512, 8'h80, 8'h70, 11'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic request(input int ratio, input bit on, output int code, output int lat);
    while (!req_ready) step();
    req_valid = 1'b1; req_ratio = 11'(ratio); req_on = on;
    step();
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid && lat < 3000) begin step(); lat++; end
    code = resp_valid ? int'(resp_code) : -1;
  endtask

  task automatic measure_period(input int r, output int per, output int hi);
    int n;
    n = 0;
    while (!(card_clk == 1'b0) && n < 2000) begin step(); n++; end
    while (card_clk == 1'b0 && n < 4000) begin step(); n++; end
    per = 0; hi = 0;
    while (per < 2 * r + 4) begin
      if (card_clk) hi++;
      step(); per++;
      if (card_clk && per > 1 && hi > 0 && !card_clk_prev) break;
      card_clk_prev = card_clk;
    end
  endtask
  bit card_clk_prev;

  task automatic run_tmo(input int r, input int len, input string tag);
    int n;
    int exp;
    data_wait = 1'b1;
    n = 0;
    while (!tmo_pulse && n < 20000) begin step(); n++; end
    exp = len * r;
    chk((n >= exp - r - 2) && (n <= exp + r + 2), tag, n, exp);
    step();
    chk(!tmo_pulse, {tag, " single"}, tmo_pulse, 0);
    data_wait = 1'b0;
    step();
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int code, lat, per, hi;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk(div_code == 8'h80, "R10 reset code", div_code, 8'h80);
    chk(!clk_running && !card_clk, "R10 reset stopped", card_clk, 0);
    chk(req_ready, "R10 reset ready", req_ready, 1);
    chk(tmo_sel == 8'h70, "R8 reset sel", tmo_sel, 8'h70);

    // table walk: R1 R2 R5 R6 R7 R8
    for (int i = 0; i < 10; i++) begin
      int r, c, s, l;
      r = int'(VEC[i][37:27]); c = int'(VEC[i][26:19]);
      s = int'(VEC[i][18:11]); l = int'(VEC[i][10:0]);
      request(r, 1'b1, code, lat);
      chk(code == 0, "R5 change ok", code, 0);
      chk(div_code == 8'(c), (r < 4) ? "R1 code" : "R2 code", div_code, c);
      chk(tmo_sel == 8'(s), "R8 sel", tmo_sel, s);
      chk(clk_running, "R5 restarted", clk_running, 1);
      if (r == 1) begin
        step();
        chk(card_clk, "R6 pass-through high phase", card_clk, 1);
      end else begin
        card_clk_prev = 1'b0;
        measure_period(r, per, hi);
        chk(per == r, "R6 period", per, r);
        chk(hi == r / 2, "R6 high phase", hi, r / 2);
      end
      run_tmo(r, l, "R7 timeout");
    end

    // R4 already running at 512
    request(512, 1'b1, code, lat);
    chk(code == 0 && lat == 1, "R4 immediate", lat, 1);
    chk(div_code == 8'h80 && clk_running, "R4 unchanged", div_code, 8'h80);

    // R3 busy reject
    cmd_busy = 1'b1;
    request(8, 1'b1, code, lat);
    chk(code == 1 && lat == 1, "R3 busy code", code, 1);
    chk(div_code == 8'h80, "R3 unchanged", div_code, 8'h80);
    request(3, 1'b1, code, lat);
    chk(code == 1, "R9 busy before param", code, 1);
    cmd_busy = 1'b0;

    // R9 invalid ratios
    request(3, 1'b1, code, lat);
    chk(code == 2 && lat == 1, "R9 ratio 3", code, 2);
    request(0, 1'b1, code, lat);
    chk(code == 2, "R9 ratio 0", code, 2);
    request(1024, 1'b1, code, lat);
    chk(code == 2, "R9 ratio 1024", code, 2);
    chk(div_code == 8'h80 && clk_running, "R9 unchanged", div_code, 8'h80);

    // R10 stop holds low, stop ignores ratio field
    request(3, 1'b0, code, lat);
    chk(code == 0 && !clk_running, "R10 stop ok", code, 0);
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 1200; j++) begin step(); if (card_clk) seen++; end
      chk(seen == 0, "R10 held low", seen, 0);
    end
    chk(div_code == 8'h80, "R10 code kept", div_code, 8'h80);

    // R4 counterpart: same ratio while stopped must restart
    request(512, 1'b1, code, lat);
    chk(code == 0 && clk_running, "R5 restart same ratio", clk_running, 1);

    // R7 early release gives no pulse
    request(2, 1'b1, code, lat);
    data_wait = 1'b1;
    repeat (300) step();
    data_wait = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 1500; j++) begin step(); if (tmo_pulse) seen++; end
      chk(seen == 0, "R7 release clears", seen, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule